// File: doc/BRIEF.md
# Complementary Mosaic Luma/Chroma Separator

This block sits right after the digitizer of a complementary-mosaic CCD. The sensor uses yellow, cyan, magenta and green filters and is read out in field-mixed mode, so every incoming sample is the sum of two filter colours. The block pairs adjacent samples on each line. For each pair it emits one luma value and one colour-difference value. The colour difference is red-minus-luma on one line type and negated blue-minus-luma on the other, and the line types alternate from line to line.

Before any sum or difference is taken, the block subtracts a black level from every sample. The black level is the floor average of the first 2^`OB_LOG2` optical-black samples of a line. It stays in force until a later line supplies a full set of black samples again. Each output carries a tag bit that says which colour difference it holds, and one valid strobe comes out per completed pair. Low-pass filtering, gamma and RGB matrixing belong to later stages.

Top module: `mosaic_lc_sep`

## Requirements
- R1: After reset, `out_vld_o` is low, `luma_o`, `chroma_o` and `cd_tag_o` are zero, and the black level in use is zero.
- R2: A sample with `sol_i` and `sof_i` both high starts a line of type 0 (pairs of (G+Cy),(Mg+Ye); tag 0 = red-minus-luma). A sample with `sol_i` high and `sof_i` low starts a line whose type is the inverse of the previous line's (type 1: (Mg+Cy),(G+Ye); tag 1 = negated blue-minus-luma). `cd_tag_o` equals the type of the line the pair came from.
- R3: Active samples (`smp_vld_i` high, `ob_i` low) are paired in arrival order, counting from the `sol_i` sample. Idle cycles between two samples do not break a pair. An unpaired last sample of a line produces no output.
- R4: With a' and b' being the first and second sample of a pair minus the black level (signed), `luma_o` = floor((a'+b')/2) as a signed `SMP_W+1`-bit value.
- R5: `chroma_o` = b' − a' as a signed `SMP_W+2`-bit value, on both line types.
- R6: `out_vld_o` is high for exactly one cycle: the cycle after the clock edge that accepts the second sample of a pair. It never stays high for two cycles in a row.
- R7: The floor average of the first 2^`OB_LOG2` samples of a line that have `ob_i` high becomes the black level. It applies from the next accepted sample onward. Further black samples on the same line are ignored, and a line with fewer black samples leaves the level unchanged.
- R8: Samples with `ob_i` high produce no output and take no part in pairing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| smp_vld_i | input | 1 | Sample strobe |
| smp_i | input | SMP_W | Unsigned sample |
| sol_i | input | 1 | Sample is the first of a line |
| sof_i | input | 1 | With sol_i: line is the first of a field |
| ob_i | input | 1 | Sample lies in the optical-black window |
| luma_o | output | SMP_W+1 | Signed luma |
| chroma_o | output | SMP_W+2 | Signed colour difference |
| cd_tag_o | output | 1 | 0 = red-minus-luma, 1 = negated blue-minus-luma |
| out_vld_o | output | 1 | Output strobe |

## Verification
A line-type register that is out of step shows up on the first pair of the affected line as a wrong `cd_tag_o`. It persists until the next field start brings the line type back into line. A pair phase that is off by one makes the first and second samples swap roles on the next pair: the chroma sign flips, or a trailing sample gets mixed into the next line, and this shows at the next strobe. A wrong black accumulator gives the same offset on every luma value once the black set of a line completes, and it leaves chroma untouched. For that reason the bench checks luma and chroma separately after each black update.

// File: rtl/mosaic_lc_pkg.sv
package mosaic_lc_pkg;
  typedef enum logic {
    CD_RMY = 1'b0,  // red minus luma
    CD_BMY = 1'b1   // negated blue minus luma
  } cd_kind_e;
endpackage

// File: rtl/mlc_line_track.sv
module mlc_line_track
  import mosaic_lc_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     smp_vld_i,
  input  logic     sol_i,
  input  logic     sof_i,
  input  logic     ob_i,
  output cd_kind_e kind_o,
  output logic     first_o,
  output logic     second_o
);
  cd_kind_e line_q;
  logic     phase_q;
  logic     act;

  assign act = smp_vld_i & ~ob_i;

  always_comb begin
    kind_o = line_q;
    if (smp_vld_i && sol_i) kind_o = sof_i ? CD_RMY : cd_kind_e'(~line_q);
  end

  assign second_o = act & ~sol_i & phase_q;
  assign first_o  = act & ~second_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      line_q  <= CD_RMY;
      phase_q <= 1'b0;
    end else if (smp_vld_i) begin
      if (sol_i) begin
        line_q  <= kind_o;
        phase_q <= act;
      end else if (act) begin
        phase_q <= ~phase_q;
      end
    end
  end

  AST_LINE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(smp_vld_i && sol_i) |=> $stable(line_q)); // R2

endmodule

// File: rtl/mlc_black_est.sv
module mlc_black_est #(
  parameter int SMP_W   = 10,
  parameter int OB_LOG2 = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             smp_vld_i,
  input  logic             sol_i,
  input  logic             ob_i,
  input  logic [SMP_W-1:0] smp_i,
  output logic [SMP_W-1:0] blk_o
);
  localparam int N     = 1 << OB_LOG2;
  localparam int CNT_W = OB_LOG2 + 1;
  localparam int ACC_W = SMP_W + OB_LOG2;

  logic [CNT_W-1:0] cnt_q, base_cnt;
  logic [ACC_W-1:0] acc_q, base_acc, nxt_acc;
  logic [SMP_W-1:0] blk_q;
  logic             take, done;

  always_comb begin
    base_cnt = sol_i ? '0 : cnt_q;
    base_acc = sol_i ? '0 : acc_q;
    nxt_acc  = base_acc + ACC_W'(smp_i);
    take     = smp_vld_i & ob_i & (base_cnt != CNT_W'(N));
    done     = take & (base_cnt == CNT_W'(N - 1));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      acc_q <= '0;
      blk_q <= '0;
    end else begin
      if (take) begin
        cnt_q <= base_cnt + CNT_W'(1);
        acc_q <= nxt_acc;
      end else if (smp_vld_i && sol_i) begin
        cnt_q <= '0;
        acc_q <= '0;
      end
      if (done) blk_q <= nxt_acc[ACC_W-1:OB_LOG2];
    end
  end

  assign blk_o = blk_q;

  AST_BLK_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(blk_q) |-> $past(smp_vld_i && ob_i)); // R7

endmodule

// File: rtl/mlc_pair_calc.sv
module mlc_pair_calc
  import mosaic_lc_pkg::*;
#(
  parameter int SMP_W = 10
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    first_i,
  input  logic                    second_i,
  input  cd_kind_e                kind_i,
  input  logic [SMP_W-1:0]        smp_i,
  input  logic [SMP_W-1:0]        blk_i,
  output logic signed [SMP_W:0]   luma_o,
  output logic signed [SMP_W+1:0] chroma_o,
  output logic                    tag_o,
  output logic                    vld_o
);
  logic signed [SMP_W:0]   cor, c0_q;
  logic        [SMP_W+1:0] sum, dif;

  always_comb begin
    cor = $signed({1'b0, smp_i}) - $signed({1'b0, blk_i});
    sum = {cor[SMP_W], cor} + {c0_q[SMP_W], c0_q};
    dif = {cor[SMP_W], cor} - {c0_q[SMP_W], c0_q};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      c0_q     <= '0;
      luma_o   <= '0;
      chroma_o <= '0;
      tag_o    <= 1'b0;
      vld_o    <= 1'b0;
    end else begin
      vld_o <= second_i;
      if (first_i) c0_q <= cor;
      if (second_i) begin
        luma_o   <= $signed(sum[SMP_W+1:1]);  // floor halving
        chroma_o <= $signed(dif);
        tag_o    <= kind_i;
      end
    end
  end

  AST_VLD_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld_o |=> !vld_o); // R6

endmodule

// File: rtl/mosaic_lc_sep.sv
module mosaic_lc_sep
  import mosaic_lc_pkg::*;
#(
  parameter int SMP_W   = 10,
  parameter int OB_LOG2 = 5
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    smp_vld_i,
  input  logic [SMP_W-1:0]        smp_i,
  input  logic                    sol_i,
  input  logic                    sof_i,
  input  logic                    ob_i,
  output logic signed [SMP_W:0]   luma_o,
  output logic signed [SMP_W+1:0] chroma_o,
  output logic                    cd_tag_o,
  output logic                    out_vld_o
);
  cd_kind_e         kind;
  logic             first, second;
  logic [SMP_W-1:0] blk;

  mlc_line_track u_line (
    .clk_i, .rst_ni, .smp_vld_i, .sol_i, .sof_i, .ob_i,
    .kind_o(kind), .first_o(first), .second_o(second)
  );

  mlc_black_est #(.SMP_W(SMP_W), .OB_LOG2(OB_LOG2)) u_black (
    .clk_i, .rst_ni, .smp_vld_i, .sol_i, .ob_i, .smp_i, .blk_o(blk)
  );

  mlc_pair_calc #(.SMP_W(SMP_W)) u_pair (
    .clk_i, .rst_ni, .first_i(first), .second_i(second), .kind_i(kind),
    .smp_i, .blk_i(blk), .luma_o, .chroma_o, .tag_o(cd_tag_o), .vld_o(out_vld_o)
  );

  AST_NO_OB_OUT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_vld_o |-> $past(smp_vld_i) && !$past(ob_i)); // R8

  AST_NO_SOL_OUT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_vld_o |-> !$past(sol_i)); // R3

endmodule

// File: tb/mosaic_lc_sep_bench.sv
module mosaic_lc_sep_bench;
  localparam int SMP_W   = 10;
  localparam int OB_LOG2 = 5;
  localparam int NOB     = 1 << OB_LOG2;
  localparam int CLK_P   = 10;

  logic                    clk = 1'b0;
  logic                    rst_n = 1'b0;
  logic                    vld = 1'b0, sol = 1'b0, sof = 1'b0, ob = 1'b0;
  logic [SMP_W-1:0]        smp = '0;
  logic signed [SMP_W:0]   luma;
  logic signed [SMP_W+1:0] chroma;
  logic                    tag, ovld;

  int nchk = 0, nfail = 0, ncap = 0;
  int cap_l[64], cap_c[64], cap_t[64];

  always #(CLK_P/2) clk = ~clk;

  mosaic_lc_sep #(.SMP_W(SMP_W), .OB_LOG2(OB_LOG2)) u_mosaic_lc_sep (
    .clk_i(clk), .rst_ni(rst_n), .smp_vld_i(vld), .smp_i(smp), .sol_i(sol),
    .sof_i(sof), .ob_i(ob), .luma_o(luma), .chroma_o(chroma),
    .cd_tag_o(tag), .out_vld_o(ovld)
  );

  always @(negedge clk) begin
    if (rst_n && ovld && ncap < 64) begin
      cap_l[ncap] = int'(luma);
      cap_c[ncap] = int'(chroma);
      cap_t[ncap] = int'(tag);
      ncap++;
    end
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s %s act=%0d exp=%0d", req, what, act, exp);
    end
  endtask

  task automatic drive(input int s, input bit l, input bit f, input bit o);
    @(negedge clk);
    vld = 1'b1; smp = SMP_W'(s); sol = l; sof = f; ob = o;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      vld = 1'b0; sol = 1'b0; sof = 1'b0; ob = 1'b0;
    end
  endtask

  // expected pair from raw samples and black level
  task automatic chk_pair(input string req, input int idx, input int a, input int b,
                          input int blk, input int t);
    int ac, bc;
    ac = a - blk;
    bc = b - blk;
    chk(req, "luma", cap_l[idx], (ac + bc) >>> 1);
    chk(req, "chroma", cap_c[idx], bc - ac);
    chk(req, "tag", cap_t[idx], t);
  endtask

  task automatic t_reset();
    chk("R1", "out_vld", int'(ovld), 0);
    chk("R1", "luma", int'(luma), 0);
    chk("R1", "chroma", int'(chroma), 0);
    chk("R1", "tag", int'(tag), 0);
  endtask

  task automatic t_basic();
    ncap = 0;
    drive(100, 1, 1, 0); drive(300, 0, 0, 0);   // black 0 from reset (R1)
    drive(500, 0, 0, 0); drive(200, 0, 0, 0);
    drive(1023, 0, 0, 0); drive(1023, 0, 0, 0);
    drive(0, 0, 0, 0); drive(1023, 0, 0, 0);
    drive(1023, 0, 0, 0); drive(0, 0, 0, 0);
    drive(10, 1, 0, 0); drive(20, 0, 0, 0);     // toggled line
    drive(7, 1, 0, 0); drive(8, 0, 0, 0);
    idle(3);
    chk("R3", "count", ncap, 7);
    chk_pair("R1", 0, 100, 300, 0, 0);
    chk_pair("R4", 1, 500, 200, 0, 0);
    chk_pair("R5", 2, 1023, 1023, 0, 0);
    chk_pair("R5", 3, 0, 1023, 0, 0);
    chk_pair("R5", 4, 1023, 0, 0, 0);
    chk_pair("R2", 5, 10, 20, 0, 1);
    chk_pair("R4", 6, 7, 8, 0, 0);
  endtask

  task automatic t_latency();
    drive(50, 1, 1, 0);
    @(negedge clk);
    chk("R6", "vld after first", int'(ovld), 0);
    vld = 1'b1; smp = SMP_W'(51); sol = 1'b0; sof = 1'b0; ob = 1'b0;
    @(negedge clk);
    vld = 1'b0;
    chk("R6", "vld after second", int'(ovld), 1);
    @(negedge clk);
    chk("R6", "vld one cycle", int'(ovld), 0);
  endtask

  task automatic t_pairing();
    ncap = 0;
    drive(10, 1, 1, 0); idle(2);
    drive(500, 0, 0, 1);                        // black inside a pair (R8)
    drive(30, 0, 0, 0);
    drive(99, 0, 0, 0);                         // unpaired tail
    idle(1);
    drive(40, 1, 0, 0); drive(60, 0, 0, 0);
    idle(3);
    chk("R3", "count", ncap, 2);
    chk_pair("R3", 0, 10, 30, 0, 0);
    chk_pair("R3", 1, 40, 60, 0, 1);
  endtask

  task automatic t_sof();
    ncap = 0;
    drive(1, 1, 1, 0); drive(3, 0, 0, 0);
    drive(1, 1, 0, 0); drive(3, 0, 0, 0);
    drive(1, 1, 0, 0); drive(3, 0, 0, 0);
    drive(1, 1, 1, 0); drive(3, 0, 0, 0);       // toggle would give 1
    idle(3);
    chk("R2", "count", ncap, 4);
    chk("R2", "tag l0", cap_t[0], 0);
    chk("R2", "tag l1", cap_t[1], 1);
    chk("R2", "tag l2", cap_t[2], 0);
    chk("R2", "tag preset", cap_t[3], 0);
  endtask

  task automatic t_black();
    int sum;
    ncap = 0;
    sum = 0;
    for (int i = 0; i < NOB; i++) begin
      drive(i + 50, i == 0, i == 0, 1);
      sum += i + 50;
    end
    for (int i = 0; i < 3; i++) drive(1000, 0, 0, 1);  // beyond the set
    drive(65, 0, 0, 0); drive(65, 0, 0, 0);
    drive(0, 0, 0, 0);  drive(165, 0, 0, 0);
    drive(0, 0, 0, 0);  drive(0, 0, 0, 0);
    for (int i = 0; i < NOB; i++) drive(200, i == 0, 0, 1);
    drive(200, 0, 0, 0); drive(210, 0, 0, 0);   // right after the set
    for (int i = 0; i < 10; i++) drive(900, i == 0, 0, 1);
    drive(200, 0, 0, 0); drive(210, 0, 0, 0);   // partial set: level kept
    idle(3);
    chk("R8", "count", ncap, 5);
    chk("R7", "avg", sum / NOB, 65);
    chk_pair("R7", 0, 65, 65, 65, 0);
    chk_pair("R4", 1, 0, 165, 65, 0);
    chk_pair("R4", 2, 0, 0, 65, 0);
    chk_pair("R7", 3, 200, 210, 200, 1);
    chk_pair("R7", 4, 200, 210, 200, 0);
  endtask

  initial begin
    #(CLK_P * 200000);
    nfail++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_latency();
    t_pairing();
    t_sof();
    t_black();
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule